// File: doc/BRIEF.md
# Link Training Watchdog Recovery Sequencer

This block brings up a serial link after a start pulse and supervises the training that follows. It first pins the speed capability field to first-generation operation, then turns on the training state machine. After that it polls a link status word. When the link is not yet up, it reads the PHY receive-status register through an indirect PHY register port. If the training state machine sits in the recovery receiver-lock state while the PHY reports no valid receive data, the speed change is taken to be stuck. The sequencer then pulses two override enables in a PHY register with a timed read-modify-write.

The sequencer ends in one of two ways. It pulses `done` when the link comes up. It raises `timed_out` when a fixed number of polls fail. All delays are counted in clock cycles: a parameter gives the cycles per microsecond, so the poll interval and the override hold time scale with it.

Top module: `link_recover_seq`

## Requirements
- R1: During and after synchronous reset, `busy`, `done`, `timed_out`, `ltssm_en`, `cap_we` and `phy_req` are all 0.
- R2: The clock edge that accepts `start` is followed by a one-cycle `cap_we` pulse, with `cap_wdata` = {`cap_in`[31:4], 4'h1}. `ltssm_en` goes to 1 one cycle later and stays high until the next accepted start.
- R3: The link counts as up only when `link_word` bit 4 is 1 and bit 29 is 0. A poll that sees the link up ends the run with a one-cycle `done` pulse, and `busy` falls on the same edge.
- R4: Each poll that finds the link down issues exactly one PHY read of address 0x100D. Bit 0 of the returned data is the receive-valid flag.
- R5: Recovery starts only when the receive-valid bit is 0 and `state_word`[5:0] equals 0x0D. In every other case no PHY access is made to address 0x1005 during that poll.
- R6: Recovery first reads 0x1005 and writes back the value OR 0x0028. It then waits at least RECOV_US*CYC_PER_US cycles, reads 0x1005 again, and writes back the value AND NOT 0x0028. PHY writes go only to 0x1005.
- R7: Successive polls are at least POLL_US*CYC_PER_US cycles apart. After MAX_POLLS polls without link-up, `timed_out` is set and `busy` falls. Exactly MAX_POLLS reads of 0x100D occur in that run.
- R8: A `start` pulse while `busy` is high is ignored: it produces no new `cap_we` pulse and does not disturb the run.
- R9: The PHY port carries one transaction at a time, and `phy_req`, `phy_we`, `phy_addr` and `phy_wdata` hold steady until `phy_ack` or `phy_err`. An error on the receive-status read counts as no stall, so no recovery is made for that poll.
- R10: An accepted `start` clears `timed_out` by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for a bring-up run |
| cap_in | input | 32 | Current link capability word |
| state_word | input | 32 | Debug word; bits 5:0 hold the training state code |
| link_word | input | 32 | Debug word; bit 4 link up, bit 29 training in progress |
| phy_rdata | input | 16 | PHY register read data |
| phy_ack | input | 1 | PHY transaction completed |
| phy_err | input | 1 | PHY transaction failed |
| cap_we | output | 1 | Write strobe for the capability word |
| cap_wdata | output | 32 | Capability word limited to first generation |
| ltssm_en | output | 1 | Enable for the training state machine |
| phy_req | output | 1 | PHY transaction request |
| phy_we | output | 1 | PHY transaction is a write |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the link is up |
| timed_out | output | 1 | Poll limit reached without link-up |

## Verification
`cap_we` and `cap_wdata` are due one cycle after the edge that samples `start`, and `ltssm_en` one cycle after that. The bench samples both at the two falling edges that follow the start pulse. `done` is due on the same edge where `busy` falls, so the bench samples both at the first falling edge that shows `busy` low. The PHY-side results depend on how long the PHY model takes to acknowledge, so no fixed cycle is expected for them. The PHY model logs every transaction when it acknowledges and checks the spacing against the minimum gaps for the poll interval and the override hold. Counts of reads and writes are compared with values worked out from the scenario once `busy` has dropped.

// File: rtl/lrs_pkg.sv
`timescale 1ns/1ps
package lrs_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ENA, S_CHECK, S_RXRD, S_ORD1, S_OWR1, S_HOLD, S_ORD2, S_OWR2, S_WAIT
  } seq_st_t;

  localparam logic [15:0] RXSTAT_ADDR  = 16'h100D;
  localparam logic [15:0] OVRD_ADDR    = 16'h1005;
  localparam logic [15:0] OVRD_MASK    = 16'h0028; // data enable bit 5, PLL enable bit 3
  localparam logic [5:0]  RCVRLOCK_ST  = 6'h0D;
  localparam int          LINKUP_BIT   = 4;
  localparam int          TRAINING_BIT = 29;
  localparam int          STATE_BITS   = 6;
  localparam int          SPEED_BITS   = 4;
endpackage

// File: rtl/lrs_timer.sv
`timescale 1ns/1ps
module lrs_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expired
);
  logic [TW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      run     <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        cnt <= len;
        run <= 1'b1;
      end else if (run) begin
        if (cnt <= TW'(1)) begin
          run     <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt - TW'(1);
        end
      end
    end
  end

  AST_TMR_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
    load |-> !run); // R7
endmodule

// File: rtl/lrs_phy_if.sv
`timescale 1ns/1ps
module lrs_phy_if #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          op_we,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          xfer_done,
  output logic          xfer_err,
  output logic [DW-1:0] xfer_rdata,
  output logic          phy_req,
  output logic          phy_we,
  output logic [AW-1:0] phy_addr,
  output logic [DW-1:0] phy_wdata,
  input  logic [DW-1:0] phy_rdata,
  input  logic          phy_ack,
  input  logic          phy_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phy_req    <= 1'b0;
      phy_we     <= 1'b0;
      phy_addr   <= '0;
      phy_wdata  <= '0;
      xfer_done  <= 1'b0;
      xfer_err   <= 1'b0;
      xfer_rdata <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (!phy_req) begin
        if (go) begin
          phy_req   <= 1'b1;
          phy_we    <= op_we;
          phy_addr  <= op_addr;
          phy_wdata <= op_wdata;
        end
      end else if (phy_ack || phy_err) begin
        phy_req    <= 1'b0;
        xfer_done  <= 1'b1;
        xfer_err   <= phy_err;
        xfer_rdata <= phy_rdata;
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (phy_req && !phy_ack && !phy_err) |=>
      (phy_req && $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata))); // R9
  AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    go |-> !phy_req); // R9
endmodule

// File: rtl/link_recover_seq.sv
`timescale 1ns/1ps
module link_recover_seq #(
  parameter int CYC_PER_US = 125,
  parameter int POLL_US    = 10,
  parameter int RECOV_US   = 3000,
  parameter int MAX_POLLS  = 2000,
  parameter int WORD_W     = 32,
  parameter int PHY_AW     = 16,
  parameter int PHY_DW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] cap_in,
  input  logic [WORD_W-1:0] state_word,
  input  logic [WORD_W-1:0] link_word,
  input  logic [PHY_DW-1:0] phy_rdata,
  input  logic              phy_ack,
  input  logic              phy_err,
  output logic              cap_we,
  output logic [WORD_W-1:0] cap_wdata,
  output logic              ltssm_en,
  output logic              phy_req,
  output logic              phy_we,
  output logic [PHY_AW-1:0] phy_addr,
  output logic [PHY_DW-1:0] phy_wdata,
  output logic              busy,
  output logic              done,
  output logic              timed_out
);
  import lrs_pkg::*;

  localparam int POLL_CYC  = POLL_US * CYC_PER_US;
  localparam int RECOV_CYC = RECOV_US * CYC_PER_US;
  localparam int LONGEST   = (POLL_CYC > RECOV_CYC) ? POLL_CYC : RECOV_CYC;
  localparam int TW        = $clog2(LONGEST + 1);
  localparam int PW        = $clog2(MAX_POLLS + 1);
  localparam logic [PHY_AW-1:0] A_RX   = PHY_AW'(RXSTAT_ADDR);
  localparam logic [PHY_AW-1:0] A_OVRD = PHY_AW'(OVRD_ADDR);
  localparam logic [PHY_DW-1:0] M_OVRD = PHY_DW'(OVRD_MASK);

  seq_st_t           st;
  logic [PW-1:0]     poll_cnt;
  logic [PHY_DW-1:0] ovrd_val;
  logic              go, op_we;
  logic [PHY_AW-1:0] op_addr;
  logic [PHY_DW-1:0] op_wdata;
  logic              xfer_done, xfer_err;
  logic [PHY_DW-1:0] xfer_rdata;
  logic              tmr_load, tmr_exp;
  logic [TW-1:0]     tmr_len;
  logic              link_up, stalled;

  assign link_up = link_word[LINKUP_BIT] && !link_word[TRAINING_BIT];
  assign stalled = (state_word[STATE_BITS-1:0] == RCVRLOCK_ST);

  logic unused_bits;
  assign unused_bits = ^{cap_in[SPEED_BITS-1:0], state_word[WORD_W-1:STATE_BITS]};

  lrs_phy_if #(.AW(PHY_AW), .DW(PHY_DW)) u_phy (
    .clk(clk), .rst(rst), .go(go), .op_we(op_we), .op_addr(op_addr),
    .op_wdata(op_wdata), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .xfer_rdata(xfer_rdata), .phy_req(phy_req), .phy_we(phy_we),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_rdata(phy_rdata),
    .phy_ack(phy_ack), .phy_err(phy_err)
  );

  lrs_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .len(tmr_len), .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      poll_cnt  <= '0;
      ovrd_val  <= '0;
      go        <= 1'b0;
      op_we     <= 1'b0;
      op_addr   <= '0;
      op_wdata  <= '0;
      tmr_load  <= 1'b0;
      tmr_len   <= '0;
      cap_we    <= 1'b0;
      cap_wdata <= '0;
      ltssm_en  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      timed_out <= 1'b0;
    end else begin
      done     <= 1'b0;
      cap_we   <= 1'b0;
      go       <= 1'b0;
      tmr_load <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          busy      <= 1'b1;
          timed_out <= 1'b0;
          ltssm_en  <= 1'b0;
          cap_we    <= 1'b1;
          cap_wdata <= {cap_in[WORD_W-1:SPEED_BITS], SPEED_BITS'(1)};
          poll_cnt  <= '0;
          st        <= S_ENA;
        end
        S_ENA: begin
          ltssm_en <= 1'b1;
          st       <= S_CHECK;
        end
        S_CHECK: if (link_up) begin
          done <= 1'b1;
          busy <= 1'b0;
          st   <= S_IDLE;
        end else begin
          go      <= 1'b1;
          op_we   <= 1'b0;
          op_addr <= A_RX;
          st      <= S_RXRD;
        end
        S_RXRD: if (xfer_done) begin
          if (!xfer_err && !xfer_rdata[0] && stalled) begin
            go      <= 1'b1;
            op_we   <= 1'b0;
            op_addr <= A_OVRD;
            st      <= S_ORD1;
          end else begin
            tmr_load <= 1'b1;
            tmr_len  <= TW'(POLL_CYC);
            st       <= S_WAIT;
          end
        end
        S_ORD1: if (xfer_done) begin
          if (xfer_err) begin
            tmr_load <= 1'b1;
            tmr_len  <= TW'(POLL_CYC);
            st       <= S_WAIT;
          end else begin
            ovrd_val <= xfer_rdata | M_OVRD;
            go       <= 1'b1;
            op_we    <= 1'b1;
            op_addr  <= A_OVRD;
            op_wdata <= xfer_rdata | M_OVRD;
            st       <= S_OWR1;
          end
        end
        S_OWR1: if (xfer_done) begin
          tmr_load <= 1'b1;
          tmr_len  <= TW'(RECOV_CYC);
          st       <= S_HOLD;
        end
        S_HOLD: if (tmr_exp) begin
          go      <= 1'b1;
          op_we   <= 1'b0;
          op_addr <= A_OVRD;
          st      <= S_ORD2;
        end
        S_ORD2: if (xfer_done) begin
          go       <= 1'b1;
          op_we    <= 1'b1;
          op_addr  <= A_OVRD;
          op_wdata <= (xfer_err ? ovrd_val : xfer_rdata) & ~M_OVRD;
          st       <= S_OWR2;
        end
        S_OWR2: if (xfer_done) begin
          tmr_load <= 1'b1;
          tmr_len  <= TW'(POLL_CYC);
          st       <= S_WAIT;
        end
        S_WAIT: if (tmr_exp) begin
          if (poll_cnt == PW'(MAX_POLLS - 1)) begin
            timed_out <= 1'b1;
            busy      <= 1'b0;
            st        <= S_IDLE;
          end else begin
            poll_cnt <= poll_cnt + PW'(1);
            st       <= S_CHECK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !phy_req); // R9
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !timed_out)); // R3
  AST_CAP_BEFORE_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(ltssm_en) |-> $past(cap_we)); // R2
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
    poll_cnt < PW'(MAX_POLLS)); // R7
  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (rst)
    (phy_req && phy_we) |-> (phy_addr == A_OVRD)); // R6
endmodule

// File: tb/sim_link_recover_seq.sv
`timescale 1ns/1ps
module sim_link_recover_seq;
  localparam int CPU = 2, PU = 3, RU = 10, MP = 6;
  localparam logic [15:0] A_RX = 16'h100D, A_OV = 16'h1005, MSK = 16'h0028;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [31:0] cap_in = '0, state_word, link_word;
  logic [15:0] phy_rdata = '0;
  logic phy_ack = 1'b0, phy_err = 1'b0;
  logic cap_we, ltssm_en, phy_req, phy_we, busy, done, timed_out;
  logic [31:0] cap_wdata;
  logic [15:0] phy_addr, phy_wdata;

  always #4 clk = ~clk;

  link_recover_seq #(.CYC_PER_US(CPU), .POLL_US(PU), .RECOV_US(RU), .MAX_POLLS(MP)) u0 (
    .clk(clk), .rst(rst), .start(start), .cap_in(cap_in), .state_word(state_word),
    .link_word(link_word), .phy_rdata(phy_rdata), .phy_ack(phy_ack), .phy_err(phy_err),
    .cap_we(cap_we), .cap_wdata(cap_wdata), .ltssm_en(ltssm_en), .phy_req(phy_req),
    .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata), .busy(busy),
    .done(done), .timed_out(timed_out));

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scenario knobs and PHY / link model
  int m_up = 0, m_lat = 0, wcnt = 0;
  bit m_train = 0, m_rxv = 0, m_err = 0;
  logic [5:0] m_lt = 6'h00;
  logic [25:0] m_noise = '0;
  int n_rx = 0, n_ord = 0, n_owr = 0, n_cap = 0, wr_bad = 0, gap_bad = 0, pgap_bad = 0, odd_bad = 0;
  logic [15:0] ovrd_reg = '0;
  bit wphase = 0;
  longint last_w1 = 0, last_rx = -1;

  assign link_word  = (n_rx >= m_up) ? 32'h0000_0010 : (m_train ? 32'h2000_0010 : 32'h0);
  assign state_word = {m_noise, m_lt};

  always @(negedge clk) begin
    if (cap_we) n_cap++;
    if (phy_ack || phy_err) begin
      phy_ack = 1'b0; phy_err = 1'b0; wcnt = 0;
    end else if (phy_req) begin
      if (wcnt >= m_lat) begin
        if (phy_addr == A_RX && !phy_we) begin
          n_rx++;
          if (last_rx >= 0 && cyc - last_rx < PU * CPU) pgap_bad++;
          last_rx = cyc;
          if (m_err) begin phy_err = 1'b1; phy_rdata = 16'h0; end
          else begin phy_ack = 1'b1; phy_rdata = {15'h0, m_rxv}; end
        end else if (phy_addr == A_OV && !phy_we) begin
          n_ord++;
          if (wphase && cyc - last_w1 < RU * CPU) gap_bad++;
          phy_rdata = ovrd_reg; phy_ack = 1'b1;
        end else if (phy_addr == A_OV && phy_we) begin
          n_owr++;
          if (phy_wdata != (wphase ? (ovrd_reg & ~MSK) : (ovrd_reg | MSK))) wr_bad++;
          ovrd_reg = phy_wdata;
          wphase = !wphase;
          if (wphase) last_w1 = cyc;
          phy_ack = 1'b1;
        end else begin
          odd_bad++; phy_ack = 1'b1;
        end
      end else wcnt++;
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run(input int up, input logic [5:0] lt, input bit rxv, input bit train,
                     input bit err, input int lat, input bit poke);
    bit exp_to, finished;
    int exp_rx, exp_rec;
    logic [31:0] cv;
    m_up = up; m_lt = lt; m_rxv = rxv; m_train = train; m_err = err; m_lat = lat;
    m_noise = 26'($urandom);
    n_rx = 0; n_ord = 0; n_owr = 0; n_cap = 0; wr_bad = 0; gap_bad = 0; pgap_bad = 0;
    odd_bad = 0; wphase = 0; last_rx = -1; ovrd_reg = 16'($urandom);
    exp_to  = (up >= MP);
    exp_rx  = exp_to ? MP : up;
    exp_rec = (lt == 6'h0D && !rxv && !err) ? exp_rx : 0;
    cv = $urandom;
    @(negedge clk); start = 1'b1; cap_in = cv;
    @(negedge clk); start = 1'b0;
    chk(cap_we == 1'b1, "R2 cap_we", cap_we, 1);
    chk(cap_wdata == {cv[31:4], 4'h1}, "R2 cap_wdata", cap_wdata, {cv[31:4], 4'h1});
    chk(timed_out == 1'b0, "R10 timed_out cleared", timed_out, 0);
    @(negedge clk);
    chk(ltssm_en == 1'b1 && cap_we == 1'b0, "R2 ltssm_en", {ltssm_en, cap_we}, 2'b10);
    finished = 0;
    for (int i = 0; i < 5000 && !finished; i++) begin
      @(negedge clk);
      if (!busy) finished = 1;
      else if (poke && i == 5) begin start = 1'b1; @(negedge clk); start = 1'b0; end
    end
    chk(finished, "R7 run ends", finished, 1);
    chk(done == !exp_to, "R3 done", done, !exp_to);
    chk(timed_out == exp_to, "R7 timed_out", timed_out, exp_to);
    chk(n_rx == exp_rx, "R4 rx-valid reads", n_rx, exp_rx);
    chk(n_ord == 2 * exp_rec && n_owr == 2 * exp_rec, "R5 override accesses", n_ord + n_owr, 4 * exp_rec);
    chk(wr_bad == 0 && gap_bad == 0 && odd_bad == 0, "R6 override values and hold", wr_bad + gap_bad + odd_bad, 0);
    chk(pgap_bad == 0, "R7 poll spacing", pgap_bad, 0);
    chk(n_cap == 1, "R8 single cap write", n_cap, 1);
    @(negedge clk);
    chk(done == 1'b0 && phy_req == 1'b0, "R3 done is one pulse", {done, phy_req}, 0);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (5) @(negedge clk);
    chk({busy, done, timed_out, ltssm_en, cap_we, phy_req} == 6'b0, "R1 reset outputs",
        {busy, done, timed_out, ltssm_en, cap_we, phy_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, timed_out, ltssm_en, cap_we, phy_req} == 6'b0, "R1 idle after reset",
        {busy, done, timed_out, ltssm_en, cap_we, phy_req}, 0);
    run(0, 6'h0D, 0, 0, 0, 1, 0);   // R3 link already up: no PHY access
    run(3, 6'h11, 0, 1, 0, 2, 0);   // R3 training bit blocks link-up; R5 no recovery
    run(2, 6'h0D, 0, 0, 0, 1, 0);   // R6 stalled: two recoveries
    run(3, 6'h0D, 1, 0, 0, 0, 0);   // R5 receive valid blocks recovery
    run(MP + 2, 6'h03, 0, 1, 0, 1, 1); // R7 timeout; R8 start while busy
    run(1, 6'h0D, 0, 0, 0, 3, 0);   // R10 follows timeout
    run(4, 6'h0D, 0, 0, 1, 1, 0);   // R9 error on rx-valid read
    run(MP, 6'h0D, 0, 1, 0, 2, 1);  // R6 R7 timeout while stalled
    for (int k = 0; k < 8; k++) begin
      run($urandom_range(0, MP + 1), ($urandom_range(0, 1) != 0) ? 6'h0D : 6'($urandom),
          1'($urandom), 1'($urandom), 1'b0, $urandom_range(0, 3), 1'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule